// File: doc/BRIEF.md
# Fault Latch and Alert Controller

This block keeps the six sticky fault flags of a supervised power switch and decides whether the switch may conduct. Each flag is set by a live condition input and held until something clears it. A register-bus write clears flags by writing zeros. Several hardware events also clear flags: a turn-off command, a filtered undervoltage, a supply lockout, and a falling edge of the enable input. A flag whose condition is still present cannot be cleared.

The block also drives an open-drain alert line, modelled as a "pull low" output. The line is asserted while any latched fault has not yet been acknowledged. A single-cycle alert-response acknowledge is answered with a one-cycle response and silences the line. The line asserts again only when a different flag sets, or when an acknowledged flag is cleared and then sets again. A separate forced-low request can also drive the line, as a general-purpose output. While the line is low only because of that request, the block gives no response to an acknowledge.

The switch permission output works in one of two modes. When auto-retry is off, permission follows the latched flags. When auto-retry is on, it follows only the live conditions. In both modes a live overcurrent removes permission in the same cycle.

Top module: `fault_alert_ctrl`

## Requirements
- R1: A bus write with `bus_wr`=1 clears, at the next clock edge, every flag whose bit in `bus_wdata` is 0. Flags whose bit is 1 keep their value.
- R2: A flag whose `cond_live` bit is 1 at a clock edge is set after that edge, whatever clear event happens in the same cycle. Setting always wins over clearing.
- R3: A falling edge of `on_in`, or of `ctl_on` (each measured from one sampled edge to the next), clears all six flags.
- R4: When `uv_low` has been 1 at `UV_CYCLES` consecutive clock edges, all six flags are cleared at the last of those edges. If `uv_low` drops to 0 at any edge, the count starts again.
- R5: `uvlo`=1 at a clock edge clears all six flags.
- R6: A falling edge of `en_in` clears flags 0, 1, 2, 3 and 5, and sets flag 4 (bit 4 of `fault_q`).
- R7: `alert_pull_low` is 1 while any latched flag is unacknowledged. An `ara_ack` pulse in that state makes `ara_resp` 1 in the following cycle, and the alert is then released.
- R8: Once the alert is acknowledged, flags that stay set do not assert it again. It asserts again when a new flag sets, or when an acknowledged flag is cleared and later sets again.
- R9: `gpo_force`=1 drives `alert_pull_low` to 1. While no unacknowledged fault exists, an `ara_ack` produces no `ara_resp`.
- R10: With `auto_retry`=0, `sw_permit` is 0 while flag 0, 1 or 2 is latched, and returns to 1 as soon as those flags are cleared. Flags 3 to 5 do not affect it.
- R11: With `auto_retry`=1, `sw_permit` is 0 only while `cond_live` bit 0, 1 or 2 is 1. Latched flags are ignored, and the mode never clears them.
- R12: A live overcurrent (`cond_live` bit 2) drops `sw_permit` in the same cycle, in either mode.
- R13: After reset, `fault_q` is 0, `alert_pull_low` is 0 and `ara_resp` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_live | input | 6 | Live fault conditions, one per flag (bit 2 = overcurrent) |
| bus_wr | input | 1 | Register write strobe for the fault flags |
| bus_wdata | input | 6 | Write data; a 0 clears the matching flag |
| on_in | input | 1 | External on command; a falling edge clears all flags |
| ctl_on | input | 1 | Register on bit; a falling edge clears all flags |
| en_in | input | 1 | Enable input; a falling edge clears flags 0-3 and 5, and sets flag 4 |
| uv_low | input | 1 | Undervoltage below the reset threshold |
| uvlo | input | 1 | Internal supply lockout |
| auto_retry | input | 1 | Selects auto-retry permission mode |
| gpo_force | input | 1 | Forces the alert line low as a general-purpose output |
| ara_ack | input | 1 | Single-cycle alert-response acknowledge |
| fault_q | output | 6 | Latched fault flags |
| alert_pull_low | output | 1 | 1 = pull the open-drain alert line low |
| ara_resp | output | 1 | One-cycle response to an acknowledge |
| sw_permit | output | 1 | Switch may be on |

## Verification
The bus-clear path is driven from a table of cases. Each case pairs a preloaded flag pattern with write data that is all zeros, all ones, alternating bits, or complementary to the flags, and some cases also hold live conditions. Together these cases show apart write-zero-clears from write-one-keeps, and a plain clear from one blocked by a live condition. Directed sequences then cover each hardware clear event, both with and without a live condition, so that all-bit clears can be told apart from the enable edge's partial clear and set. Further directed sequences check that an undervoltage run one cycle short does nothing, and that a broken run restarts the count. The alert is acknowledged and then met with a persistent flag, a new flag, and a cleared-then-reoccurring flag, to show that it re-arms only on true new events. Permission is checked in both modes against latched-only and live-only faults.

// File: rtl/fault_alert_pkg.sv
package fault_alert_pkg;
  localparam int NFLT = 6;
  localparam int EN_BIT = 4;
  localparam logic [NFLT-1:0] ALL_MASK = '1;
  localparam logic [NFLT-1:0] EN_SET_MASK = NFLT'(1) << EN_BIT;
  localparam logic [NFLT-1:0] EN_CLR_MASK = ~EN_SET_MASK;
  localparam logic [NFLT-1:0] HOLD_OFF_MASK = NFLT'(7);

  typedef logic [NFLT-1:0] flags_t;

  // set beats clear; live conditions are folded into the set mask
  function automatic flags_t flags_next(input flags_t q, input flags_t clr,
                                        input flags_t set);
    return (q & ~clr) | set;
  endfunction

  // permission: overcurrent always blocks; mode picks latched vs live view
  function automatic logic permit_calc(input logic retry, input flags_t live,
                                       input flags_t q);
    logic blocked;
    if (retry) blocked = |(live & HOLD_OFF_MASK);
    else       blocked = |(q & HOLD_OFF_MASK);
    return !live[2] && !blocked;
  endfunction
endpackage

// File: rtl/uv_filter.sv
module uv_filter #(
  parameter int UV_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_low,
  output logic uv_hit
);
  localparam int CW = $clog2(UV_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(UV_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign uv_hit = uv_low && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!uv_low)    cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assert_uv_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_low |=> (cnt == '0));
  assert_uv_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/fault_latch.sv
module fault_latch
  import fault_alert_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t cond_live,
  input  logic   bus_wr,
  input  flags_t bus_wdata,
  input  logic   on_in,
  input  logic   ctl_on,
  input  logic   en_in,
  input  logic   uv_hit,
  input  logic   uvlo,
  output flags_t fault_q
);
  logic on_prev, ctl_prev, en_prev;
  logic off_evt, en_fall, full_clr;
  flags_t clr_mask, set_mask;

  assign off_evt  = (on_prev && !on_in) || (ctl_prev && !ctl_on);
  assign en_fall  = en_prev && !en_in;
  assign full_clr = off_evt || uv_hit || uvlo;

  always_comb begin
    clr_mask = '0;
    if (bus_wr)   clr_mask = clr_mask | ~bus_wdata;
    if (full_clr) clr_mask = clr_mask | ALL_MASK;
    if (en_fall)  clr_mask = clr_mask | EN_CLR_MASK;
    set_mask = cond_live | (en_fall ? EN_SET_MASK : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_prev  <= 1'b0;
      ctl_prev <= 1'b0;
      en_prev  <= 1'b0;
      fault_q  <= '0;
    end else begin
      on_prev  <= on_in;
      ctl_prev <= ctl_on;
      en_prev  <= en_in;
      fault_q  <= flags_next(fault_q, clr_mask, set_mask);
    end
  end

  assert_live_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|cond_live) |=> ((fault_q & $past(cond_live)) == $past(cond_live)));
  assert_w1_keeps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !full_clr && !en_fall)
      |=> ((fault_q & $past(bus_wdata & fault_q)) == $past(bus_wdata & fault_q)));
  assert_full_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_clr && cond_live == '0 && !en_fall) |=> (fault_q == '0));
  assert_en_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> fault_q[EN_BIT]);
  assert_en_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && cond_live == '0) |=> ((fault_q & EN_CLR_MASK) == '0));
endmodule

// File: rtl/alert_ctrl.sv
module alert_ctrl
  import fault_alert_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t fault_q,
  input  logic   gpo_force,
  input  logic   ara_ack,
  output logic   alert_pull_low,
  output logic   ara_resp
);
  flags_t acked;
  logic   alert_fault;
  logic   respond;

  assign alert_fault    = |(fault_q & ~acked);
  assign respond        = ara_ack && alert_fault;
  assign alert_pull_low = alert_fault || gpo_force;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acked    <= '0;
      ara_resp <= 1'b0;
    end else begin
      // an acked bit is forgotten as soon as its flag clears
      acked    <= respond ? fault_q : (acked & fault_q);
      ara_resp <= respond;
    end
  end

  assert_resp_needs_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ara_resp |-> ($past(alert_fault) && $past(ara_ack)));
  assert_no_resp_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_fault |=> !ara_resp);
  assert_quiet_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (respond && $stable(fault_q)) |=> (fault_q != $past(fault_q)) || !alert_fault);
endmodule

// File: rtl/fault_alert_ctrl.sv
module fault_alert_ctrl
  import fault_alert_pkg::*;
#(
  parameter int UV_CYCLES = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] cond_live,
  input  logic       bus_wr,
  input  logic [5:0] bus_wdata,
  input  logic       on_in,
  input  logic       ctl_on,
  input  logic       en_in,
  input  logic       uv_low,
  input  logic       uvlo,
  input  logic       auto_retry,
  input  logic       gpo_force,
  input  logic       ara_ack,
  output logic [5:0] fault_q,
  output logic       alert_pull_low,
  output logic       ara_resp,
  output logic       sw_permit
);
  logic uv_hit;

  uv_filter #(.UV_CYCLES(UV_CYCLES)) u_uv (
    .clk(clk), .rst_n(rst_n), .uv_low(uv_low), .uv_hit(uv_hit)
  );

  fault_latch u_latch (
    .clk(clk), .rst_n(rst_n), .cond_live(cond_live), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .on_in(on_in), .ctl_on(ctl_on), .en_in(en_in),
    .uv_hit(uv_hit), .uvlo(uvlo), .fault_q(fault_q)
  );

  alert_ctrl u_alert (
    .clk(clk), .rst_n(rst_n), .fault_q(fault_q), .gpo_force(gpo_force),
    .ara_ack(ara_ack), .alert_pull_low(alert_pull_low), .ara_resp(ara_resp)
  );

  assign sw_permit = permit_calc(auto_retry, cond_live, fault_q);

  assert_latched_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_retry && |fault_q[2:0]) |-> !sw_permit);
  assert_retry_ignores_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_retry && cond_live[2:0] == 3'b000) |-> sw_permit);
  assert_retry_keeps_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_retry && !bus_wr && !uvlo && !uv_hit && !$fell(on_in) && !$fell(ctl_on)
     && !$fell(en_in) && $past(rst_n)) |=> ((fault_q & $past(fault_q)) == $past(fault_q)));
endmodule

// File: tb/test_fault_alert_ctrl.sv
module test_fault_alert_ctrl;
  localparam int UVC = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] cond_live = '0, bus_wdata = '0;
  logic bus_wr = 0, on_in = 1, ctl_on = 1, en_in = 1, uv_low = 0, uvlo = 0;
  logic auto_retry = 0, gpo_force = 0, ara_ack = 0;
  logic [5:0] fault_q;
  logic alert_pull_low, ara_resp, sw_permit;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fault_alert_ctrl #(.UV_CYCLES(UVC)) i_fault_alert_ctrl (
    .clk(clk), .rst_n(rst_n), .cond_live(cond_live), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .on_in(on_in), .ctl_on(ctl_on), .en_in(en_in),
    .uv_low(uv_low), .uvlo(uvlo), .auto_retry(auto_retry), .gpo_force(gpo_force),
    .ara_ack(ara_ack), .fault_q(fault_q), .alert_pull_low(alert_pull_low),
    .ara_resp(ara_resp), .sw_permit(sw_permit)
  );

  // {preload, wr, wdata, live, expected}
  localparam logic [24:0] VEC [8] = '{
    {6'h3F, 1'b1, 6'h00, 6'h00, 6'h00},
    {6'h3F, 1'b1, 6'h2A, 6'h00, 6'h2A},
    {6'h15, 1'b1, 6'h3F, 6'h00, 6'h15},
    {6'h3F, 1'b1, 6'h00, 6'h05, 6'h05},
    {6'h00, 1'b0, 6'h00, 6'h12, 6'h12},
    {6'h0F, 1'b1, 6'h30, 6'h00, 6'h00},
    {6'h3F, 1'b1, 6'h0F, 6'h20, 6'h2F},
    {6'h21, 1'b0, 6'h00, 6'h00, 6'h21}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load(input logic [5:0] m);
    cond_live = m; tick(); cond_live = '0;
  endtask

  task automatic wipe();
    uvlo = 1; tick(); uvlo = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R13 reset state
    chk("R13 fault_q", fault_q, 0);
    chk("R13 alert", alert_pull_low, 0);
    chk("R13 resp", ara_resp, 0);
    rst_n = 1; tick();

    // R1/R2 table
    foreach (VEC[i]) begin
      wipe();
      load(VEC[i][24:19]);
      bus_wr = VEC[i][18]; bus_wdata = VEC[i][17:12]; cond_live = VEC[i][11:6];
      tick();
      bus_wr = 0; cond_live = '0;
      chk("R1/R2 vector", fault_q, 32'(VEC[i][5:0]));
    end

    // R3 on falling edge / control bit falling edge
    wipe(); load(6'h3F);
    on_in = 0; tick(); on_in = 1;
    chk("R3 on fall", fault_q, 0);
    load(6'h3F);
    ctl_on = 0; cond_live = 6'h08; tick(); ctl_on = 1; cond_live = '0;
    chk("R3 ctl fall with live", fault_q, 6'h08);
    tick();
    chk("R3 rising no clear", fault_q, 6'h08);

    // R4 UV filter
    uv_low = 1; repeat (UVC - 1) tick();
    chk("R4 one short", fault_q, 6'h08);
    uv_low = 0; tick(); uv_low = 1;
    repeat (UVC - 1) tick();
    chk("R4 restart", fault_q, 6'h08);
    tick(); uv_low = 0;
    chk("R4 full run", fault_q, 0);

    // R5 lockout
    load(6'h3F); wipe();
    chk("R5 uvlo", fault_q, 0);
    load(6'h3F); uvlo = 1; cond_live = 6'h02; tick(); uvlo = 0; cond_live = '0;
    chk("R5 uvlo blocked by live", fault_q, 6'h02);

    // R6 enable falling edge
    load(6'h3F); en_in = 0; tick();
    chk("R6 en fall from all", fault_q, 6'h10);
    en_in = 1; wipe(); en_in = 0; tick(); en_in = 1;
    chk("R6 en fall from none", fault_q, 6'h10);
    tick();

    // R7/R8 alert
    wipe(); tick();
    cond_live = 6'h01; tick();
    chk("R7 alert on fault", alert_pull_low, 1);
    ara_ack = 1; tick(); ara_ack = 0;
    chk("R7 resp", ara_resp, 1);
    chk("R7 released", alert_pull_low, 0);
    tick();
    chk("R7 resp one cycle", ara_resp, 0);
    chk("R8 persistent quiet", alert_pull_low, 0);
    cond_live = 6'h03; tick();
    chk("R8 new bit alerts", alert_pull_low, 1);
    ara_ack = 1; tick(); ara_ack = 0; cond_live = '0;
    chk("R8 second ack", alert_pull_low, 0);
    bus_wr = 1; bus_wdata = 6'h3E; tick(); bus_wr = 0;
    chk("R8 cleared bit0", fault_q, 6'h02);
    chk("R8 still quiet", alert_pull_low, 0);
    cond_live = 6'h01; tick(); cond_live = '0;
    chk("R8 reoccur alerts", alert_pull_low, 1);

    // R9 forced output
    wipe(); tick(); ara_ack = 1; tick(); ara_ack = 0; tick();
    gpo_force = 1; #1;
    chk("R9 forced low", alert_pull_low, 1);
    tick(); ara_ack = 1; tick(); ara_ack = 0;
    chk("R9 no resp", ara_resp, 0);
    gpo_force = 0; #1;
    chk("R9 release", alert_pull_low, 0);

    // R10/R12 no auto-retry
    tick(); auto_retry = 0;
    chk("R10 permit clean", sw_permit, 1);
    cond_live = 6'h04; #1;
    chk("R12 overcurrent immediate", sw_permit, 0);
    tick(); cond_live = '0; #1;
    chk("R10 latched bit2 blocks", sw_permit, 0);
    tick(); bus_wr = 1; bus_wdata = 6'h3B; tick(); bus_wr = 0; #1;
    chk("R10 cleared permits", sw_permit, 1);
    tick(); load(6'h38); #1;
    chk("R10 bits3-5 ignored", sw_permit, 1);

    // R11/R12 auto-retry
    tick(); load(6'h03); auto_retry = 1; #1;
    chk("R11 latch ignored", sw_permit, 1);
    cond_live = 6'h02; #1;
    chk("R11 live bit1 blocks", sw_permit, 0);
    cond_live = 6'h04; #1;
    chk("R12 overcurrent retry", sw_permit, 0);
    cond_live = 6'h08; tick(); cond_live = '0; #1;
    chk("R11 live bit3 permits", sw_permit, 1);
    repeat (3) tick();
    chk("R11 flags not cleared", fault_q, 6'h3B);

    summary();
    $finish;
  end
endmodule